// File: doc/BRIEF.md
# Signed Wallace Tree Multiplier

A purely combinational multiplier for two signed operands of N bits each. It returns their full 2N-bit two's complement product. The width N is a parameter. The block has no clock, no reset and no handshake: the product follows the operands through the logic.

Internally the block works in three steps. First it forms a partial product matrix in which every dot has positive weight: the sign-row terms are inverted and two constant ones are injected. Next a greedy Wallace column-compression tree of half and full adders works from the least significant column upward, one pass at a time, until no column is taller than two bits. Low columns that end up holding a single bit feed the product directly. Last, a Kogge-Stone parallel prefix adder adds the two remaining rows from the first column taller than one bit up to the top.

Top module: `swm_wallace_mult`

## Requirements
- R1: For N=4, `product` equals the signed product of `mcand` and `mplier` for all 256 operand pairs, as an 8-bit two's complement value.
- R2: For N=6, `product` equals the signed product for all 4096 operand pairs, as a 12-bit two's complement value.
- R3: The dot matrix is built as follows. The term a_i·b_j is inverted when exactly one of i and j equals N-1, and kept true otherwise. Constant ones are added at column N and column 2N-1. The weighted sum of all dots, taken modulo 2^(2N), equals the signed product.
- R4: The compression tree keeps the weighted value of the matrix unchanged, modulo 2^(2N). Within one pass it uses only bits present at the start of that pass. A sum goes to its own column and a carry goes to the next column, and any carry out of column 2N-1 is dropped.
- R5: The final prefix adder returns the sum of its two row operands modulo 2^width, and discards the carry out of its top bit.
- R6: `product` is zero whenever either operand is zero.
- R7: With both operands at the most negative value -2^(N-1), `product` is +2^(2N-2) and does not wrap. The most negative value times the most positive value gives -2^(2N-2)+2^(N-1).
- R8: An operand of -1 yields the two's complement negation of the other operand, widened to 2N bits. This includes negating the most negative value.
- R9: For N=16, `product` matches the signed product for random operand pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| product | output | 2N | Signed product, two's complement |

## Verification
Exhaustive sweeps at N=4 and N=6 reach every sign combination, and so they show whether the inverted sign-row terms and the two injected constants are right. Directed pairs at N=16 single out specific faults. A zero operand exposes stray constants. An operand of -1 exposes carry-chain errors across the whole prefix adder. The most negative squared value sets only bit 2N-2, so it shows whether the top-column carry is dropped correctly. Random signed pairs at N=16 cover the deep trees, where a reduction pass that is scheduled wrongly would appear.

// File: rtl/swm_pkg.sv
`timescale 1ns/1ps
package swm_pkg;

  // number of dots in column c of the sign-corrected matrix for width n
  function automatic int initHeight(int n, int c);
    int h;
    h = 0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        if (i + j == c) h++;
    if (c == n) h++;
    if (c == 2 * n - 1) h++;
    return h;
  endfunction

  function automatic int maxHeight(int n);
    return n + 2;
  endfunction

  function automatic int passLimit(int n);
    return 3 * $clog2(n) + 3;
  endfunction

  // replays the pass schedule on column heights only; returns first column taller than one
  function automatic int firstWideCol(int n);
    int h [0:255];
    int nh [0:255];
    int mx, hs, adders, carryIn;
    for (int c = 0; c < 256; c++) h[c] = (c < 2 * n) ? initHeight(n, c) : 0;
    for (int p = 0; p < passLimit(n); p++) begin
      mx = 0;
      for (int c = 0; c < 2 * n; c++) if (h[c] > mx) mx = h[c];
      if (mx > 2) begin
        carryIn = 0;
        for (int c = 0; c < 2 * n; c++) begin
          hs = h[c];
          adders = hs / 3 + ((hs % 3 == 2) ? 1 : 0);
          nh[c] = ((hs % 3 == 1) ? 1 : 0) + carryIn + adders;
          carryIn = adders;
        end
        for (int c = 0; c < 2 * n; c++) h[c] = nh[c];
      end
    end
    for (int c = 0; c < 2 * n; c++) if (h[c] > 1) return c;
    return 2 * n;
  endfunction

endpackage

// File: rtl/swm_pp_gen.sv
`timescale 1ns/1ps
module swm_pp_gen #(
  parameter int N = 16,
  localparam int COLS = 2 * N,
  localparam int MAXH = swm_pkg::maxHeight(N)
) (
  input  logic [N-1:0]                   mcand,
  input  logic [N-1:0]                   mplier,
  output logic [COLS-1:0][MAXH-1:0]      colBits
);

  int   fill [COLS];
  logic dot;
  logic [COLS-1:0] weightSum;
  logic signed [COLS-1:0] refProd;

  always_comb begin
    colBits = '0;
    for (int c = 0; c < COLS; c++) fill[c] = 0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        dot = mcand[i] & mplier[j];
        if ((i == N - 1) != (j == N - 1)) dot = ~dot;
        colBits[i+j][fill[i+j]] = dot;
        fill[i+j] = fill[i+j] + 1;
      end
    end
    colBits[N][fill[N]] = 1'b1;
    fill[N] = fill[N] + 1;
    colBits[COLS-1][fill[COLS-1]] = 1'b1;
    fill[COLS-1] = fill[COLS-1] + 1;

    weightSum = '0;
    for (int c = 0; c < COLS; c++)
      for (int k = 0; k < MAXH; k++)
        if (colBits[c][k]) weightSum = weightSum + (COLS'(1) << c);
    refProd = COLS'($signed(mcand) * $signed(mplier));
    // R3: all-positive matrix carries the signed product
    a_r3_matrix_value: assert (weightSum == refProd)
      else $error("matrix value differs from signed product");
  end

endmodule

// File: rtl/swm_compress.sv
`timescale 1ns/1ps
module swm_compress #(
  parameter int N = 16,
  localparam int COLS = 2 * N,
  localparam int MAXH = swm_pkg::maxHeight(N),
  localparam int NPASS = swm_pkg::passLimit(N),
  localparam int START = swm_pkg::firstWideCol(N),
  localparam int ADDW = COLS - START
) (
  input  logic [COLS-1:0][MAXH-1:0] colBits,
  output logic [START-1:0]          lowBits,
  output logic [ADDW-1:0]           rowA,
  output logic [ADDW-1:0]           rowB
);

  logic mat [COLS][MAXH];
  logic tmp [COLS][MAXH];
  int   matH [COLS];
  int   tmpH [COLS];
  logic carryQ [MAXH];
  logic carryNew [MAXH];
  int   carryN, carryNewN, mx, hs, pos, top;
  logic x, y, z;
  logic [COLS-1:0] inSum, outSum;

  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      matH[c] = swm_pkg::initHeight(N, c);
      tmpH[c] = 0;
      for (int k = 0; k < MAXH; k++) begin
        mat[c][k] = colBits[c][k];
        tmp[c][k] = 1'b0;
      end
    end
    for (int k = 0; k < MAXH; k++) begin
      carryQ[k] = 1'b0;
      carryNew[k] = 1'b0;
    end
    carryN = 0; carryNewN = 0; hs = 0; pos = 0; top = 0;
    x = 1'b0; y = 1'b0; z = 1'b0;

    for (int p = 0; p < NPASS; p++) begin
      mx = 0;
      for (int c = 0; c < COLS; c++) if (matH[c] > mx) mx = matH[c];
      if (mx > 2) begin
        for (int c = 0; c < COLS; c++) begin
          tmpH[c] = 0;
          for (int k = 0; k < MAXH; k++) tmp[c][k] = 1'b0;
        end
        carryN = 0;
        for (int c = 0; c < COLS; c++) begin
          hs  = matH[c];
          top = 0;
          if (hs % 3 == 1) begin
            tmp[c][0] = mat[c][hs-1];
            top = 1;
          end
          for (int q = 0; q < MAXH; q++)
            if (q < carryN && top < MAXH) begin
              tmp[c][top] = carryQ[q];
              top = top + 1;
            end
          carryNewN = 0;
          pos = 0;
          for (int g = 0; g < MAXH; g++) begin
            if (hs - pos == 2) begin
              x = mat[c][pos]; y = mat[c][pos+1];
              if (top < MAXH) tmp[c][top] = x ^ y;
              carryNew[carryNewN] = x & y;
              top = top + 1; carryNewN = carryNewN + 1; pos = pos + 2;
            end else if (hs - pos >= 3) begin
              x = mat[c][pos]; y = mat[c][pos+1]; z = mat[c][pos+2];
              if (top < MAXH) tmp[c][top] = x ^ y ^ z;
              carryNew[carryNewN] = (x & y) | (x & z) | (y & z);
              top = top + 1; carryNewN = carryNewN + 1; pos = pos + 3;
            end
          end
          tmpH[c] = top;
          for (int q = 0; q < MAXH; q++) carryQ[q] = carryNew[q];
          carryN = carryNewN;
        end
        for (int c = 0; c < COLS; c++) begin
          matH[c] = tmpH[c];
          for (int k = 0; k < MAXH; k++) mat[c][k] = tmp[c][k];
        end
      end
    end

    for (int c = 0; c < START; c++) lowBits[c] = mat[c][0];
    for (int c = START; c < COLS; c++) begin
      rowA[c-START] = (matH[c] >= 1) ? mat[c][0] : 1'b0;
      rowB[c-START] = (matH[c] >= 2) ? mat[c][1] : 1'b0;
    end

    inSum = '0;
    for (int c = 0; c < COLS; c++)
      for (int k = 0; k < MAXH; k++)
        if (colBits[c][k]) inSum = inSum + (COLS'(1) << c);
    outSum = COLS'(lowBits) + (COLS'(rowA) << START) + (COLS'(rowB) << START);
    // R4: reduction keeps the weighted value
    a_r4_value_kept: assert (outSum == inSum)
      else $error("compression changed matrix value");
  end

endmodule

// File: rtl/swm_prefix_add.sv
`timescale 1ns/1ps
module swm_prefix_add #(
  parameter int W = 8,
  localparam int LVL = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sumOut
);

  logic [W-1:0] gen [LVL+1];
  logic [W-1:0] prop [LVL+1];

  assign gen[0]  = opA & opB;
  assign prop[0] = opA ^ opB;

  for (genvar s = 0; s < LVL; s++) begin : g_level
    localparam int DIST = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= DIST) begin : g_merge
        assign gen[s+1][i]  = gen[s][i] | (prop[s][i] & gen[s][i-DIST]);
        assign prop[s+1][i] = prop[s][i] & prop[s][i-DIST];
      end else begin : g_pass
        assign gen[s+1][i]  = gen[s][i];
        assign prop[s+1][i] = prop[s][i];
      end
    end
  end

  if (W > 1) begin : g_wide
    assign sumOut = prop[0] ^ {gen[LVL][W-2:0], 1'b0};
  end else begin : g_narrow
    assign sumOut = prop[0];
  end

  always_comb begin
    // R5: prefix result equals modular addition
    a_r5_prefix_sum: assert (sumOut == W'(opA + opB))
      else $error("prefix adder sum wrong");
    // R5: zero operand passes the other through
    if (opB == '0)
      a_r5_identity: assert (sumOut == opA)
        else $error("prefix adder identity wrong");
  end

endmodule

// File: rtl/swm_wallace_mult.sv
`timescale 1ns/1ps
module swm_wallace_mult #(
  parameter int N = 16
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] product
);

  localparam int COLS  = 2 * N;
  localparam int MAXH  = swm_pkg::maxHeight(N);
  localparam int START = swm_pkg::firstWideCol(N);
  localparam int ADDW  = COLS - START;

  logic [COLS-1:0][MAXH-1:0] colBits;
  logic [START-1:0]          lowBits;
  logic [ADDW-1:0]           rowA, rowB, rowSum;

  swm_pp_gen #(.N(N)) ppGen_i (
    .mcand  (mcand),
    .mplier (mplier),
    .colBits(colBits)
  );

  swm_compress #(.N(N)) compress_i (
    .colBits(colBits),
    .lowBits(lowBits),
    .rowA   (rowA),
    .rowB   (rowB)
  );

  swm_prefix_add #(.W(ADDW)) finalAdd_i (
    .opA   (rowA),
    .opB   (rowB),
    .sumOut(rowSum)
  );

  assign product = {rowSum, lowBits};

endmodule

// File: tb/swm_wallace_mult_tb_top.sv
`timescale 1ns/1ps
module swm_wallace_mult_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0]  a4 = '0, b4 = '0;
  logic [5:0]  a6 = '0, b6 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [7:0]  p4;
  logic [11:0] p6;
  logic [31:0] p16;

  swm_wallace_mult #(.N(16)) dut_i   (.mcand(a16), .mplier(b16), .product(p16));
  swm_wallace_mult #(.N(4))  dut4_i  (.mcand(a4),  .mplier(b4),  .product(p4));
  swm_wallace_mult #(.N(6))  dut6_i  (.mcand(a6),  .mplier(b6),  .product(p6));

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run16(string tag, longint x, longint y);
    @(posedge clk);
    a16 = 16'(x); b16 = 16'(y);
    @(negedge clk);
    check(tag, longint'($signed(p16)), x * y);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: idle state with zero operands
    check("R6 idle", longint'($signed(p16)), 0);
    check("R6 idle n4", longint'($signed(p4)), 0);

    // R1 (exercises R3, R4, R5): exhaustive N=4
    for (int x = -8; x < 8; x++)
      for (int y = -8; y < 8; y++) begin
        @(posedge clk);
        a4 = 4'(x); b4 = 4'(y);
        @(negedge clk);
        check("R1", longint'($signed(p4)), longint'(x * y));
      end

    // R2: exhaustive N=6
    for (int x = -32; x < 32; x++)
      for (int y = -32; y < 32; y++) begin
        @(posedge clk);
        a6 = 6'(x); b6 = 6'(y);
        @(negedge clk);
        check("R2", longint'($signed(p6)), longint'(x * y));
      end

    // R6: zero operand
    run16("R6", 0, 12345);
    run16("R6", -32768, 0);
    run16("R6", 0, 0);
    // R7: most negative corners
    run16("R7", -32768, -32768);
    run16("R7", -32768, 32767);
    run16("R7", 32767, 32767);
    // R8: minus one
    run16("R8", -1, 12345);
    run16("R8", -32768, -1);
    run16("R8", -1, -1);
    run16("R8", 1, -1);

    // R9: random signed pairs
    for (int k = 0; k < 3000; k++) begin
      longint x, y;
      x = longint'($signed(16'($urandom)));
      y = longint'($signed(16'($urandom)));
      if (k % 50 == 0) x = -32768;
      if (k % 70 == 0) y = -32768;
      run16("R9", x, y);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule